// File: doc/BRIEF.md
# Memory Client Quiesce and Hot-Reset Controller

This block gives software a way to take one memory client at a time out of service and bring it back, with no effect on the other clients. It holds two shared control words, each with one bit per client. The admission word decides whether a client may hand new requests to the arbiter. The hot-reset word drives that client's active-low reset. Both words use active-low semantics. A bit at 1 means the client is admitted, or is out of reset. A bit at 0 means it is blocked, or is held in reset.

The block keeps a count of the requests each client still has in flight. It adds one for every accepted request and subtracts one for every completed response. Each count can be read at its own address, and a reading of zero means the client is idle. The software procedure runs in this order:
1. Clear the client's admission bit.
2. Poll the client's status word until it reads zero.
3. Clear the client's hot-reset bit.
4. Later, set both bits again.

The register interface is a simple word-addressed port. A write takes effect at the next clock edge, and a read returns its data in the same cycle.
- Address 0 holds the admission word.
- Address 1 holds the hot-reset word.
- Address 2+i holds the outstanding count of client i.

Top module: `client_quiesce_top`

## Requirements
- R1: After reset, the admission word and the hot-reset word both read as all ones in bits [NUM_CLIENTS-1:0] (0x7FFF for 15 clients). Every outstanding count reads 0, every reqReady bit is 1 and every clientRstN bit is 1.
- R2: A write to address 0 loads the admission word from regWrData[NUM_CLIENTS-1:0] at the next clock edge. Reading address 0 returns that word, with every higher bit 0.
- R3: reqReady[i] is 1 only when admission bit i is 1, hot-reset bit i is 1 and count i is below its maximum. While admission bit i is 0, requests on client i are not counted.
- R4: A write to address 1 loads the hot-reset word at the next clock edge. clientRstN[i] equals hot-reset bit i, and reading address 1 returns the word.
- R5: Count i rises by one on a cycle with reqValid[i] and reqReady[i] both high. It falls by one on a cycle with rspDone[i] high. When both happen in the same cycle, it stays unchanged. Reading address 2+i returns count i, zero-extended.
- R6: A blocked client still drains: rspDone[i] decrements count i while admission bit i is 0.
- R7: A count saturates at both ends. At 2^CNT_W-1, reqReady[i] is 0 and further requests are not counted. At 0, rspDone[i] is ignored.
- R8: While hot-reset bit i is 0, reqReady[i] is 0 and count i is cleared to 0 one cycle later.
- R9: Writes to addresses at or above 2+NUM_CLIENTS, and to the status addresses, change nothing. Reads from addresses at or above 2+NUM_CLIENTS return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Word address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for regAddr, same cycle |
| reqValid | input | NUM_CLIENTS | Client request offered to the arbiter |
| reqReady | output | NUM_CLIENTS | Request accepted for that client this cycle |
| rspDone | input | NUM_CLIENTS | Response completed for that client |
| clientRstN | output | NUM_CLIENTS | Active-low hot reset for each client |

## Verification
The outstanding counter is first driven by a table of request and response pulses on one client. The table includes lone requests, lone responses, a request and a response in the same cycle, and a response at zero. These cases separate correct up/down counting from a counter that drops the simultaneous case or underflows. Directed sequences then block a client that has traffic in flight and check that requests freeze while responses drain. Further sequences put a busy client into hot reset to show the count clears, and fill a counter to its maximum to show ready falls and the value holds. Unmapped and status-address writes are checked by reading back both control words and watching every ready output.

// File: rtl/client_quiesce_pkg.sv
package client_quiesce_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             wrAdmit;
    logic             wrHotRst;
    logic             rdAdmit;
    logic             rdHotRst;
    logic             rdStatus;
    logic [IDX_W-1:0] statusIdx;
  } regStrobe_t;
endpackage

// File: rtl/client_quiesce_ctrl.sv
module client_quiesce_ctrl
  import client_quiesce_pkg::*;
#(
  parameter int NUM_CLIENTS = 15,
  parameter int ADDR_W      = 6
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);
  localparam int STATUS_BASE = 2;
  localparam int STATUS_END  = STATUS_BASE + NUM_CLIENTS;

  logic [31:0] addrExt;
  logic        isAdmit;
  logic        isHotRst;
  logic        isStatus;

  always_comb begin
    addrExt  = 32'(regAddr);
    isAdmit  = (addrExt == 32'd0);
    isHotRst = (addrExt == 32'd1);
    isStatus = (addrExt >= 32'(STATUS_BASE)) && (addrExt < 32'(STATUS_END));

    strobe           = '0;
    strobe.wrAdmit   = regWrEn && isAdmit;
    strobe.wrHotRst  = regWrEn && isHotRst;
    strobe.rdAdmit   = isAdmit;
    strobe.rdHotRst  = isHotRst;
    strobe.rdStatus  = isStatus;
    strobe.statusIdx = isStatus ? IDX_W'(addrExt - 32'(STATUS_BASE)) : '0;
  end
endmodule

// File: rtl/client_quiesce_dp.sv
module client_quiesce_dp
  import client_quiesce_pkg::*;
#(
  parameter int NUM_CLIENTS = 15,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strobe,
  input  logic [DATA_W-1:0]      regWrData,
  output logic [DATA_W-1:0]      regRdData,
  input  logic [NUM_CLIENTS-1:0] reqValid,
  input  logic [NUM_CLIENTS-1:0] rspDone,
  output logic [NUM_CLIENTS-1:0] reqReady,
  output logic [NUM_CLIENTS-1:0] clientRstN
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CLIENTS-1:0] admitQ;
  logic [NUM_CLIENTS-1:0] hotRstQ;
  logic [CNT_W-1:0]       outCnt [NUM_CLIENTS];
  logic [NUM_CLIENTS-1:0] accept;
  logic [NUM_CLIENTS-1:0] drain;

  // Shared control words; active low, all ones out of reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      admitQ  <= '1;
      hotRstQ <= '1;
    end else begin
      if (strobe.wrAdmit)  admitQ  <= regWrData[NUM_CLIENTS-1:0];
      if (strobe.wrHotRst) hotRstQ <= regWrData[NUM_CLIENTS-1:0];
    end
  end

  assign clientRstN = hotRstQ;

  // R2
  admit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrAdmit |=> admitQ == $past(regWrData[NUM_CLIENTS-1:0]));

  // R4
  hotrst_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrHotRst |=> clientRstN == $past(regWrData[NUM_CLIENTS-1:0]));

  // R9
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrAdmit && !strobe.wrHotRst) |=> ($stable(admitQ) && $stable(hotRstQ)));

  for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_client
    assign reqReady[i] = admitQ[i] && hotRstQ[i] && (outCnt[i] != CNT_MAX);
    assign accept[i]   = reqValid[i] && reqReady[i];
    assign drain[i]    = rspDone[i] && (outCnt[i] != '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outCnt[i] <= '0;
      end else if (!hotRstQ[i]) begin
        outCnt[i] <= '0;
      end else begin
        case ({accept[i], drain[i]})
          2'b10:   outCnt[i] <= outCnt[i] + CNT_W'(1);
          2'b01:   outCnt[i] <= outCnt[i] - CNT_W'(1);
          default: outCnt[i] <= outCnt[i];
        endcase
      end
    end

    // R5
    accept_count_chk: assert property (@(posedge clk) disable iff (!rstN)
      (accept[i] && !rspDone[i] && hotRstQ[i]) |=> outCnt[i] == $past(outCnt[i]) + CNT_W'(1));

    // R6
    drain_count_chk: assert property (@(posedge clk) disable iff (!rstN)
      (drain[i] && !accept[i] && hotRstQ[i]) |=> outCnt[i] == $past(outCnt[i]) - CNT_W'(1));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      !hotRstQ[i] |=> outCnt[i] == '0);
  end

  always_comb begin
    regRdData = '0;
    if (strobe.rdAdmit)  regRdData[NUM_CLIENTS-1:0] = admitQ;
    if (strobe.rdHotRst) regRdData[NUM_CLIENTS-1:0] = hotRstQ;
    if (strobe.rdStatus) begin
      for (int k = 0; k < NUM_CLIENTS; k++) begin
        if (strobe.statusIdx == IDX_W'(k)) regRdData[CNT_W-1:0] = outCnt[k];
      end
    end
  end
endmodule

// File: rtl/client_quiesce_top.sv
module client_quiesce_top
  import client_quiesce_pkg::*;
#(
  parameter int NUM_CLIENTS = 15,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWrData,
  output logic [DATA_W-1:0]      regRdData,
  input  logic [NUM_CLIENTS-1:0] reqValid,
  output logic [NUM_CLIENTS-1:0] reqReady,
  input  logic [NUM_CLIENTS-1:0] rspDone,
  output logic [NUM_CLIENTS-1:0] clientRstN
);
  regStrobe_t strobe;

  client_quiesce_ctrl #(
    .NUM_CLIENTS(NUM_CLIENTS),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  client_quiesce_dp #(
    .NUM_CLIENTS(NUM_CLIENTS),
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .reqValid  (reqValid),
    .rspDone   (rspDone),
    .reqReady  (reqReady),
    .clientRstN(clientRstN)
  );
endmodule

// File: tb/sim_client_quiesce_top.sv
`timescale 1ns/1ps
module sim_client_quiesce_top;
  localparam int N   = 15;
  localparam int AW  = 6;
  localparam int DW  = 32;
  localparam int CW  = 4;
  localparam logic [31:0] ALL = 32'h0000_7fff;

  // Table row: {reqValid, rspDone, 2'b00, expected count after the edge}
  localparam logic [7:0] VEC [8] = '{
    8'b1000_0001, 8'b1000_0010, 8'b1100_0010, 8'b0100_0001,
    8'b0100_0000, 8'b0100_0000, 8'b1000_0001, 8'b0100_0000
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic          regWrEn;
  logic [AW-1:0] regAddr;
  logic [DW-1:0] regWrData;
  logic [DW-1:0] regRdData;
  logic [N-1:0]  reqValid;
  logic [N-1:0]  reqReady;
  logic [N-1:0]  rspDone;
  logic [N-1:0]  clientRstN;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  client_quiesce_top #(.NUM_CLIENTS(N), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqReady(reqReady), .rspDone(rspDone), .clientRstN(clientRstN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input int addr, input logic [31:0] exp);
    @(negedge clk);
    regAddr = AW'(addr);
    #1;
    chk(req, regRdData, exp);
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(addr); regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulse(input int c, input logic rq, input logic rs);
    @(negedge clk);
    reqValid = '0; rspDone = '0;
    reqValid[c] = rq; rspDone[c] = rs;
    @(negedge clk);
    reqValid = '0; rspDone = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    reqValid = '0; rspDone = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd("R1 admit word", 0, ALL);
    rd("R1 hotrst word", 1, ALL);
    rd("R1 count", 5, 32'd0);
    chk("R1 reqReady", 32'(reqReady), ALL);
    chk("R1 clientRstN", 32'(clientRstN), ALL);

    // R5 R7 table walk on client 3 (status address 5)
    for (int v = 0; v < 8; v++) begin
      pulse(3, VEC[v][7], VEC[v][6]);
      rd("R5 table count", 5, 32'(VEC[v][3:0]));
    end

    // R2 R3 R6 block client 3 with two in flight
    pulse(3, 1'b1, 1'b0);
    pulse(3, 1'b1, 1'b0);
    wr(0, ALL & ~32'h8);
    rd("R2 admit readback", 0, ALL & ~32'h8);
    chk("R3 blocked ready", 32'(reqReady), ALL & ~32'h8);
    pulse(3, 1'b1, 1'b0);
    rd("R3 blocked request not counted", 5, 32'd2);
    pulse(3, 1'b0, 1'b1);
    rd("R6 drain while blocked", 5, 32'd1);
    pulse(3, 1'b0, 1'b1);
    rd("R6 drained to idle", 5, 32'd0);
    wr(0, 32'hffff_ffff);
    rd("R2 upper bits zero", 0, ALL);

    // R4 R8 hot reset of a busy client 5 (status address 7)
    pulse(5, 1'b1, 1'b0);
    pulse(5, 1'b1, 1'b0);
    rd("R8 count before reset", 7, 32'd2);
    wr(1, ALL & ~32'h20);
    chk("R4 clientRstN", 32'(clientRstN), ALL & ~32'h20);
    rd("R4 hotrst readback", 1, ALL & ~32'h20);
    chk("R8 ready low in reset", 32'(reqReady[5]), 32'd0);
    rd("R8 count cleared", 7, 32'd0);
    pulse(5, 1'b1, 1'b0);
    rd("R8 request ignored in reset", 7, 32'd0);
    wr(1, ALL);
    chk("R4 released", 32'(clientRstN), ALL);

    // R7 saturation on client 7 (status address 9)
    for (int k = 0; k < 15; k++) pulse(7, 1'b1, 1'b0);
    rd("R7 count at max", 9, 32'd15);
    chk("R7 ready low at max", 32'(reqReady[7]), 32'd0);
    pulse(7, 1'b1, 1'b0);
    rd("R7 holds at max", 9, 32'd15);
    pulse(7, 1'b1, 1'b1);
    rd("R7 max with both pulses drains", 9, 32'd14);
    pulse(7, 1'b1, 1'b1);
    rd("R5 simultaneous holds", 9, 32'd14);

    // R9 unmapped and status-address writes
    wr(40, 32'd0);
    wr(9, 32'd0);
    rd("R9 admit untouched", 0, ALL);
    rd("R9 hotrst untouched", 1, ALL);
    rd("R9 status untouched", 9, 32'd14);
    rd("R9 unmapped read", 40, 32'd0);
    chk("R9 ready unaffected", 32'(reqReady), ALL);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule